// File: doc/BRIEF.md
# Line-21 Closed Caption Encoder

This block produces the caption waveform that a composite video encoder mixes into its luma path on the caption line of each field. Software loads two 7-bit characters per field. The block adds an odd-parity bit to each character. On the caption line it replaces the luma samples with a seven-cycle sine run-in, the start bits and sixteen NRZ data bits. Every element is timed in units of D, one thirty-second of a line.

The timing generator of the encoder supplies a one-clock `line_strobe` at horizontal sync. On the first line of each field it also raises `field_strobe`, and `field_two` tells which field is starting. The block counts lines within the field. The 21st line is the caption line: line 21 of field one and line 284 of the frame in field two. Each field has its own enable and its own status flag. A status flag is set when characters are loaded and cleared once they have been sent. Sent characters are then zeroed, so a field that is not refilled sends null characters. A write to a field while that field's burst is pending or running is held back and takes effect when the burst ends.

Top module: `cc_line21_enc`

## Requirements
- R1: After reset `luma_vld` is 0, `luma` is 16, `status` is 2'b00, and only field one is enabled. Whenever `luma_vld` is 0, `luma` is 16.
- R2: A burst starts only on the 21st `line_strobe` of a field. The first line of a field is the strobe with `field_strobe` high, and `field_two` (0 = field one, 1 = field two) picks the field. The field's enable bit must be set.
- R3: `luma_vld` rises exactly 284 clocks after the clock in which the caption-line `line_strobe` is sampled high.
- R4: A burst lasts 26 units of D = 1716/32 clocks, 1395 clocks in total. Unit k begins ceil(1716·k/32) clocks after `luma_vld` rises, and the units are placed by a fractional accumulator with no drift.
- R5: Units 0 to 6 carry the run-in sine from a 16-step table centred on 71. It starts at 71, peaks at 126 and reaches down to 16, and 126 is entered exactly seven times.
- R6: Units 7 and 8 are start bits at 16 (logic 0). Unit 9 is a start bit at 126 (logic 1).
- R7: Units 10 to 25 send, LSB first, the seven bits of character one and then its parity bit, followed by the same for character two. The parity bit makes the number of ones in each byte odd. Logic one is 126 and logic zero is 16.
- R8: A pulse on `wr_en` loads `wr_data[6:0]` as character one and `wr_data[13:6+1]` as character two into the field chosen by `wr_fld` (0 = one, 1 = two). The field's `status` bit reads 1 from the next clock.
- R9: When a field's burst ends, that field's `status` bit clears and its characters become zero. The next burst without a write therefore sends two null bytes (0x00 plus parity 1).
- R10: A write to the field whose burst is pending or running does not change that burst. It is applied when the burst ends, and the field's `status` bit then reads 1.
- R11: A pulse on `en_we` loads `en_data` (bit 0 = field one, bit 1 = field two). A disabled field sends no burst and its `status` bit does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_strobe | input | 1 | One-clock pulse at horizontal sync of every line |
| field_strobe | input | 1 | High with `line_strobe` on the first line of a field |
| field_two | input | 1 | Field identity sampled with `field_strobe` |
| wr_en | input | 1 | Character write strobe |
| wr_fld | input | 1 | Field selected by the write |
| wr_data | input | 14 | Character two in [13:7], character one in [6:0] |
| en_we | input | 1 | Enable write strobe |
| en_data | input | 2 | Per-field enable bits |
| luma | output | 8 | Luma override level |
| luma_vld | output | 1 | High while `luma` replaces the video |
| status | output | 2 | Per-field loaded-and-not-yet-sent flags |

## Verification
The bench measures the start delay and the length of the burst to the clock. It probes both sides of the rising start bit, so a truncated or rounded unit period shows up as an off-by-one start or a shortened burst. It decodes every data bit at the middle of its unit. Bytes whose bit counts differ in parity catch an even-parity or bit-order mistake, and a design that skipped clearing would repeat stale characters where nulls are expected. A write during a running burst catches a design that corrupts the burst in flight or drops the held data. Bursts on a disabled field and on the wrong field catch errors in line counting and in field selection.

// File: rtl/cc_line21_enc.sv
module cc_line21_enc #(
  parameter int LINE_CLKS   = 1716,
  parameter int UNITS       = 32,
  parameter int START_DLY   = 284,
  parameter int CC_LINE     = 21,
  parameter int LINE_W      = 10,
  parameter int LVL_LO      = 16,
  parameter int LVL_HI      = 126,
  parameter int RUNIN_UNITS = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_strobe,
  input  logic        field_strobe,
  input  logic        field_two,
  input  logic        wr_en,
  input  logic        wr_fld,
  input  logic [13:0] wr_data,
  input  logic        en_we,
  input  logic [1:0]  en_data,
  output logic [7:0]  luma,
  output logic        luma_vld,
  output logic [1:0]  status
);
  localparam int SUB_STEPS   = 16;
  localparam int STEP        = UNITS * SUB_STEPS;
  localparam int ACC_W       = $clog2(LINE_CLKS + STEP) + 1;
  localparam int TOTAL_UNITS = RUNIN_UNITS + 3 + 16;
  localparam int UNIT_W      = $clog2(TOTAL_UNITS + 1);
  localparam int DLY_W       = $clog2(START_DLY + 1);
  localparam int MID         = (LVL_LO + LVL_HI) / 2;
  localparam int AMP         = LVL_HI - MID;

  typedef enum logic [1:0] {IDLE, WAIT, SEND} st_t;
  st_t state;

  logic [LINE_W-1:0] line_cnt, nxt_line;
  logic              fld, nxt_fld, cur_fld, hit, sub_tick, done;
  logic [1:0]        en, pend_v, wr_hit, busy_f, done_f;
  logic [1:0][13:0]  chars, pend;
  logic [DLY_W-1:0]  dly;
  logic [ACC_W-1:0]  acc, acc_n;
  logic [3:0]        sub;
  logic [UNIT_W-1:0] unit, bidx;
  logic [13:0]       cur;
  logic [15:0]       frame;

  function automatic logic [7:0] runin_lvl(input logic [3:0] p);
    logic [2:0] k;
    int q, m;
    k = (p[2:0] > 3'd4) ? 3'(4'd8 - {1'b0, p[2:0]}) : p[2:0];
    case (k)
      3'd0:    q = 0;
      3'd1:    q = 98;
      3'd2:    q = 181;
      3'd3:    q = 237;
      default: q = 256;
    endcase
    m = (AMP * q + 128) / 256;
    return p[3] ? 8'(MID - m) : 8'(MID + m);
  endfunction

  assign nxt_line = field_strobe ? LINE_W'(1) :
                    (&line_cnt ? line_cnt : line_cnt + LINE_W'(1));
  assign nxt_fld  = field_strobe ? field_two : fld;
  assign hit      = line_strobe && state == IDLE &&
                    nxt_line == LINE_W'(CC_LINE) && en[nxt_fld];

  assign acc_n    = acc + ACC_W'(STEP);
  assign sub_tick = acc_n >= ACC_W'(LINE_CLKS);
  assign done     = state == SEND && sub_tick && sub == 4'hF &&
                    unit == UNIT_W'(TOTAL_UNITS - 1);

  assign wr_hit = {wr_en && wr_fld, wr_en && !wr_fld};
  assign busy_f = (state != IDLE) ? {cur_fld, !cur_fld} : 2'b00;
  assign done_f = done ? {cur_fld, !cur_fld} : 2'b00;

  assign cur   = chars[cur_fld];
  assign frame = {~^cur[13:7], cur[13:7], ~^cur[6:0], cur[6:0]};
  assign bidx  = unit - UNIT_W'(RUNIN_UNITS + 3);

  assign luma_vld = state == SEND;
  always_comb begin
    if (state != SEND)                            luma = 8'(LVL_LO);
    else if (unit < UNIT_W'(RUNIN_UNITS))         luma = runin_lvl(sub);
    else if (unit < UNIT_W'(RUNIN_UNITS + 2))     luma = 8'(LVL_LO);
    else if (unit == UNIT_W'(RUNIN_UNITS + 2))    luma = 8'(LVL_HI);
    else luma = frame[bidx[3:0]] ? 8'(LVL_HI) : 8'(LVL_LO);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      line_cnt <= '0;
      fld      <= 1'b0;
      cur_fld  <= 1'b0;
      en       <= 2'b01;
      dly      <= '0;
      acc      <= '0;
      sub      <= '0;
      unit     <= '0;
      chars    <= '0;
      pend     <= '0;
      pend_v   <= '0;
      status   <= '0;
    end else begin
      if (line_strobe) begin
        line_cnt <= nxt_line;
        fld      <= nxt_fld;
      end
      if (en_we) en <= en_data;
      case (state)
        IDLE: if (hit) begin
          state   <= WAIT;
          cur_fld <= nxt_fld;
          dly     <= '0;
        end
        WAIT: if (dly == DLY_W'(START_DLY - 2)) begin
          state <= SEND;
          acc   <= '0;
          sub   <= '0;
          unit  <= '0;
        end else dly <= dly + DLY_W'(1);
        default: begin
          if (sub_tick) begin
            acc <= acc_n - ACC_W'(LINE_CLKS);
            sub <= sub + 4'd1;
            if (sub == 4'hF) unit <= unit + UNIT_W'(1);
          end else acc <= acc_n;
          if (done) state <= IDLE;
        end
      endcase
      for (int i = 0; i < 2; i++) begin
        if (done_f[i]) begin
          chars[i]  <= wr_hit[i] ? wr_data : (pend_v[i] ? pend[i] : 14'd0);
          status[i] <= wr_hit[i] | pend_v[i];
          pend_v[i] <= 1'b0;
        end else if (wr_hit[i]) begin
          if (busy_f[i]) begin
            pend[i]   <= wr_data;
            pend_v[i] <= 1'b1;
          end else begin
            chars[i]  <= wr_data;
            status[i] <= 1'b1;
          end
        end
      end
    end
  end

  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !luma_vld |-> luma == 8'(LVL_LO));
  // R2
  cc_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(luma_vld) |-> line_cnt == LINE_W'(CC_LINE) && en[cur_fld]);
  // R7
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    luma_vld |-> luma >= 8'(LVL_LO) && luma <= 8'(LVL_HI));
  // R10
  held_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != IDLE && $past(state != IDLE)) |-> $stable(chars[cur_fld]));
  // R9
  status0_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[0]) |-> $fell(luma_vld) && !cur_fld);
  // R9
  status1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[1]) |-> $fell(luma_vld) && cur_fld);
endmodule

// File: tb/sim_cc_line21_enc.sv
module sim_cc_line21_enc;
  logic clk = 0, rst_n = 0;
  logic line_strobe = 0, field_strobe = 0, field_two = 0;
  logic wr_en = 0, wr_fld = 0, en_we = 0;
  logic [13:0] wr_data = '0;
  logic [1:0] en_data = '0;
  logic [7:0] luma;
  logic luma_vld;
  logic [1:0] status;

  int errors = 0, checks = 0, cyc = 0, ls = 0, bursts = 0;
  int exp_q[$];
  logic [7:0] samp [0:1999];

  cc_line21_enc u0 (.*);

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_chars(input bit f, input logic [6:0] c1, input logic [6:0] c2);
    @(negedge clk);
    wr_en = 1; wr_fld = f; wr_data = {c2, c1};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_en(input logic [1:0] e);
    @(negedge clk);
    en_we = 1; en_data = e;
    @(negedge clk);
    en_we = 0;
  endtask

  function automatic int lvl(input bit b);
    return b ? 126 : 16;
  endfunction

  // driver side of the scoreboard: expected levels of units 7..25
  task automatic push_exp(input logic [6:0] c1, input logic [6:0] c2);
    exp_q.push_back(16); exp_q.push_back(16); exp_q.push_back(126);
    for (int i = 0; i < 7; i++) exp_q.push_back(lvl(c1[i]));
    exp_q.push_back(lvl(~^c1));
    for (int i = 0; i < 7; i++) exp_q.push_back(lvl(c2[i]));
    exp_q.push_back(lvl(~^c2));
  endtask

  task automatic pulse_line(input bit fs, input bit f2);
    @(negedge clk);
    line_strobe = 1; field_strobe = fs; field_two = f2;
    ls = cyc;
    @(negedge clk);
    line_strobe = 0; field_strobe = 0;
    tick(2);
  endtask

  task automatic run_field(input bit f2);
    pulse_line(1, f2);
    for (int l = 2; l <= 20; l++) pulse_line(0, 0);
    pulse_line(0, 0);
    tick(1800);
    pulse_line(0, 0);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (luma_vld) begin
        int t0, k, peaks;
        t0 = cyc; k = 0; peaks = 0;
        while (luma_vld && k < 2000) begin
          samp[k] = luma; k++;
          @(negedge clk);
        end
        bursts++;
        chk(t0 - ls == 284, "R3 start delay", t0 - ls, 284);
        chk(k == 1395, "R4 burst length", k, 1395);
        chk(samp[482] == 16 && samp[483] == 126, "R4 unit 9 edge",
            int'(samp[483]), 126);
        chk(samp[0] == 71, "R5 run-in start", int'(samp[0]), 71);
        for (int i = 0; i < 376; i++)
          if (samp[i] == 126 && (i == 0 || samp[i-1] != 126)) peaks++;
        chk(peaks == 7, "R5 run-in peaks", peaks, 7);
        for (int u = 7; u < 26; u++) begin
          int m, e;
          m = ((2 * u + 1) * 1716) / 64;
          if (exp_q.size() == 0) begin
            chk(0, "R2 unexpected burst", u, -1);
            break;
          end
          e = exp_q.pop_front();
          chk(int'(samp[m]) == e, (u < 10) ? "R6 start bit" : "R7 data bit",
              int'(samp[m]), e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int b;
    tick(5);
    chk(luma_vld == 0, "R1 vld", luma_vld, 0);
    chk(luma == 16, "R1 luma", luma, 16);
    chk(status == 0, "R1 status", status, 0);
    rst_n = 1;
    tick(3);

    write_chars(0, 7'h41, 7'h2A);
    chk(status == 2'b01, "R8 status set", status, 1);
    push_exp(7'h41, 7'h2A);
    run_field(0);
    chk(bursts == 1, "R2 field one burst", bursts, 1);
    chk(status == 2'b00, "R9 status cleared", status, 0);

    push_exp(7'h00, 7'h00);
    run_field(0);
    chk(bursts == 2, "R9 null burst", bursts, 2);

    write_chars(1, 7'h7F, 7'h00);
    chk(status == 2'b10, "R8 field two status", status, 2);
    b = bursts;
    run_field(1);
    chk(bursts == b, "R11 field two disabled by default", bursts, b);
    chk(status == 2'b10, "R11 status kept", status, 2);

    set_en(2'b11);
    push_exp(7'h7F, 7'h00);
    run_field(1);
    chk(bursts == b + 1, "R2 field two burst", bursts, b + 1);
    chk(status == 2'b00, "R9 field two cleared", status, 0);

    write_chars(0, 7'h55, 7'h13);
    push_exp(7'h55, 7'h13);
    fork
      run_field(0);
      begin
        wait (luma_vld);
        tick(100);
        write_chars(0, 7'h0C, 7'h66);
        chk(status == 2'b01, "R10 status during burst", status, 1);
      end
    join
    chk(status == 2'b01, "R10 held write applied", status, 1);
    push_exp(7'h0C, 7'h66);
    run_field(0);
    chk(status == 2'b00, "R10 held data sent", status, 0);

    set_en(2'b10);
    write_chars(0, 7'h01, 7'h02);
    b = bursts;
    run_field(0);
    chk(bursts == b, "R11 field one disabled", bursts, b);
    chk(status == 2'b01, "R11 status untouched", status, 1);
    chk(exp_q.size() == 0, "R7 all expected bursts seen", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule